// File: doc/BRIEF.md
# Multi-Channel Sync Event Distributor

This block turns one asynchronous sync strobe into per-channel, single-cycle control pulses for a four-channel receive datapath. A control word carries one 8-bit field per channel. Each field chooses which downstream units of that channel react to the next sync: the carrier and timing oscillator frequency loads, the FIR engine reset, the gain-loop reset, the decimation counter reset and the serial output reset. The strobe is first brought into the clock domain and edge-detected. Every enabled action then fires exactly once per rising edge of the strobe.

The block also gates each channel's input stream. A hardware reset closes every channel's input gate and puts the input mode into gated operation. A processor reset closes the gate only on channels whose field asks for it. A closed gate opens on the sample that lines up with the next sync. When a FIR reset fires, a busy flag covers the engine's pointer initialisation window. A new sync inside that window starts the window again. A per-channel interrupt marks each word that the channel hands to the output stage. A separate pulse asks for a serial clock divider reset.

Top module: `sync_event_distributor`

## Requirements
- R1: `sync_in` passes through a two-flop synchronizer and an edge detector. If `sync_in` is first seen high at clock edge k, the selected action pulses are high for exactly one cycle, after edge k+2.
- R2: The channel fields in `ctrl_word` are: channel 0 = bits 31:24, channel 1 = bits 23:16, channel 2 = bits 15:8, channel 3 = bits 7:0. Output bus bit n belongs to channel n.
- R3: Field bit positions are: 5 = carrier load, 4 = FIR reset, 3 = gain-loop reset, 2 = timing load, 1 = decimation counter reset, 0 = serial reset. A cleared bit produces no pulse on its output. Bits 7 and 6 produce no sync pulse.
- R4: A `sync_in` that stays high produces only one pulse per rising edge.
- R5: When a FIR reset fires, `fir_busy` for that channel rises in the same cycle as `fir_reset`. It stays high for exactly FIR_INIT_CYCLES cycles.
- R6: A FIR reset that fires while `fir_busy` is high restarts the window. Busy then lasts FIR_INIT_CYCLES cycles from the new pulse.
- R7: A `proc_rst` cycle clears `in_en` of every channel whose field bit 6 is set, from the next edge on. Channels with bit 6 clear keep `in_en` unchanged. A cleared `in_en` rises in the same cycle as the sync action pulses, and not earlier.
- R8: `rst` clears `in_en` on all channels, whatever the field bits say, and sets `gated_mode`. `gated_mode` clears one cycle after a `mode_release` pulse.
- R9: `irq[n]` is high for one cycle, one cycle after `out_strobe[n]`, if field bit 7 of channel n is set. Otherwise it stays low.
- R10: `div_reset` pulses together with the sync actions only when `div_rst_en` is high and bit 0 is set in at least one field.
- R11: After `rst`, every pulse output, `fir_busy`, `irq` and `div_reset` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| proc_rst | input | 1 | Processor reset request, one cycle |
| mode_release | input | 1 | Leaves gated input mode |
| ctrl_word | input | 32 | Per-channel control fields |
| div_rst_en | input | 1 | Allows serial divider reset on sync |
| sync_in | input | 1 | Asynchronous sync strobe |
| out_strobe | input | 4 | Per-channel output word strobe |
| carrier_load | output | 4 | Carrier frequency load pulse |
| timing_load | output | 4 | Timing frequency load pulse |
| fir_reset | output | 4 | FIR engine reset pulse |
| agc_reset | output | 4 | Gain-loop reset pulse |
| cic_reset | output | 4 | Decimation counter reset pulse |
| serial_reset | output | 4 | Serial output reset pulse |
| fir_busy | output | 4 | FIR initialisation in progress |
| in_en | output | 4 | Channel input enable |
| irq | output | 4 | Data output interrupt |
| div_reset | output | 1 | Serial clock divider reset pulse |
| gated_mode | output | 1 | Input mode is gated |

## Verification
The bench uses the default parameters: four channels, a 32-cycle FIR window and a two-stage synchronizer. This exercises the full 32-cycle busy count and the exact three-edge sync latency. The vector table covers varied placements of action bits across the four fields. A mid-window second sync checks that the busy window stretches from 32 to 45 sampled cycles. Directed cases check the per-channel hold on processor reset against the blanket hold on the reset pin.

// File: rtl/sed_pkg.sv
package sed_pkg;

    localparam int FIELD_W = 8;

    // One channel's control field, top bit first
    typedef struct packed {
        logic irq_en;
        logic hold_en;
        logic carrier_ld;
        logic fir_rst;
        logic agc_rst;
        logic timing_ld;
        logic cic_rst;
        logic ser_rst;
    } ch_cfg_t;

    // Sync-triggered actions of one channel
    typedef struct packed {
        logic carrier_ld;
        logic fir_rst;
        logic agc_rst;
        logic timing_ld;
        logic cic_rst;
        logic ser_rst;
    } ch_act_t;

    function automatic ch_act_t actions_of(ch_cfg_t c, logic fire);
        ch_act_t a;
        a.carrier_ld = fire & c.carrier_ld;
        a.fir_rst    = fire & c.fir_rst;
        a.agc_rst    = fire & c.agc_rst;
        a.timing_ld  = fire & c.timing_ld;
        a.cic_rst    = fire & c.cic_rst;
        a.ser_rst    = fire & c.ser_rst;
        return a;
    endfunction

endpackage

// File: rtl/sed_sync_edge.sv
module sed_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], async_in};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];

    // R4: a held-high strobe yields one isolated edge
    a_r4_rise_isolated: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/sed_fir_window.sv
module sed_fir_window #(
    parameter int INIT_CYCLES = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CW = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(INIT_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == LAST) busy <= 1'b0;
            else             cnt  <= cnt + 1'b1;
        end
    end

    // R5: busy only begins after a start request
    a_r5_busy_from_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));
    // R6: a start always leaves the window open with a fresh count
    a_r6_restart_clears: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && cnt == '0));
endmodule

// File: rtl/sed_channel.sv
module sed_channel
    import sed_pkg::*;
#(
    parameter int INIT_CYCLES = 32
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    proc_rst,
    input  logic    fire,
    input  ch_cfg_t cfg,
    input  logic    out_strobe,
    output ch_act_t act,
    output logic    in_en,
    output logic    irq,
    output logic    busy
);
    always_ff @(posedge clk) begin
        if (rst) begin
            act   <= '0;
            in_en <= 1'b0;
            irq   <= 1'b0;
        end else begin
            act <= actions_of(cfg, fire);
            irq <= out_strobe & cfg.irq_en;
            if (proc_rst && cfg.hold_en) in_en <= 1'b0;
            else if (fire)               in_en <= 1'b1;
        end
    end

    sed_fir_window #(.INIT_CYCLES(INIT_CYCLES)) u_win (
        .clk   (clk),
        .rst   (rst),
        .start (fire & cfg.fir_rst),
        .busy  (busy)
    );

    // R1: each action is a single-cycle pulse
    a_r1_one_shot: assert property (@(posedge clk) disable iff (rst)
        (act != '0) |=> (act == '0));
    // R7: the input gate reopens only on a sync edge
    a_r7_release_on_sync: assert property (@(posedge clk) disable iff (rst)
        $rose(in_en) |-> $past(fire));
    // R5: busy covers the FIR reset pulse cycle
    a_r5_busy_with_pulse: assert property (@(posedge clk) disable iff (rst)
        act.fir_rst |-> busy);
endmodule

// File: rtl/sync_event_distributor.sv
module sync_event_distributor
    import sed_pkg::*;
#(
    parameter int NUM_CH          = 4,
    parameter int FIR_INIT_CYCLES = 32,
    parameter int SYNC_STAGES     = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      proc_rst,
    input  logic                      mode_release,
    input  logic [NUM_CH*FIELD_W-1:0] ctrl_word,
    input  logic                      div_rst_en,
    input  logic                      sync_in,
    input  logic [NUM_CH-1:0]         out_strobe,
    output logic [NUM_CH-1:0]         carrier_load,
    output logic [NUM_CH-1:0]         timing_load,
    output logic [NUM_CH-1:0]         fir_reset,
    output logic [NUM_CH-1:0]         agc_reset,
    output logic [NUM_CH-1:0]         cic_reset,
    output logic [NUM_CH-1:0]         serial_reset,
    output logic [NUM_CH-1:0]         fir_busy,
    output logic [NUM_CH-1:0]         in_en,
    output logic [NUM_CH-1:0]         irq,
    output logic                      div_reset,
    output logic                      gated_mode
);
    logic              fire;
    logic [NUM_CH-1:0] ser_sel;

    sed_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (sync_in),
        .rise     (fire)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        ch_cfg_t cfg;
        ch_act_t act;
        // channel 0 occupies the most significant field
        assign cfg = ch_cfg_t'(ctrl_word[(NUM_CH-1-g)*FIELD_W +: FIELD_W]);
        assign ser_sel[g] = cfg.ser_rst;

        sed_channel #(.INIT_CYCLES(FIR_INIT_CYCLES)) u_ch (
            .clk        (clk),
            .rst        (rst),
            .proc_rst   (proc_rst),
            .fire       (fire),
            .cfg        (cfg),
            .out_strobe (out_strobe[g]),
            .act        (act),
            .in_en      (in_en[g]),
            .irq        (irq[g]),
            .busy       (fir_busy[g])
        );

        assign carrier_load[g] = act.carrier_ld;
        assign timing_load[g]  = act.timing_ld;
        assign fir_reset[g]    = act.fir_rst;
        assign agc_reset[g]    = act.agc_rst;
        assign cic_reset[g]    = act.cic_rst;
        assign serial_reset[g] = act.ser_rst;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_reset  <= 1'b0;
            gated_mode <= 1'b1;
        end else begin
            div_reset <= fire & div_rst_en & (|ser_sel);
            if (mode_release) gated_mode <= 1'b0;
        end
    end

    // R10: divider reset needs the enable in the preceding cycle
    a_r10_div_needs_enable: assert property (@(posedge clk) disable iff (rst)
        div_reset |-> $past(div_rst_en));
    // R8: gated mode leaves only on request
    a_r8_gated_exit: assert property (@(posedge clk) disable iff (rst)
        $fell(gated_mode) |-> $past(mode_release));
endmodule

// File: tb/sync_event_distributor_test.sv
module sync_event_distributor_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        proc_rst = 1'b0;
    logic        mode_release = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic        div_rst_en = 1'b0;
    logic        sync_in = 1'b0;
    logic [3:0]  out_strobe = '0;
    logic [3:0]  carrier_load, timing_load, fir_reset, agc_reset;
    logic [3:0]  cic_reset, serial_reset, fir_busy, in_en, irq;
    logic        div_reset, gated_mode;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sync_event_distributor uut (
        .clk(clk), .rst(rst), .proc_rst(proc_rst), .mode_release(mode_release),
        .ctrl_word(ctrl_word), .div_rst_en(div_rst_en), .sync_in(sync_in),
        .out_strobe(out_strobe), .carrier_load(carrier_load),
        .timing_load(timing_load), .fir_reset(fir_reset), .agc_reset(agc_reset),
        .cic_reset(cic_reset), .serial_reset(serial_reset), .fir_busy(fir_busy),
        .in_en(in_en), .irq(irq), .div_reset(div_reset), .gated_mode(gated_mode)
    );

    // {div_rst_en, ctrl_word}
    localparam logic [32:0] VEC [8] = '{
        {1'b1, 32'h3F3F_3F3F}, {1'b1, 32'h0000_0000},
        {1'b0, 32'h2000_0000}, {1'b0, 32'h0004_0000},
        {1'b1, 32'h0000_0801}, {1'b0, 32'h0100_0000},
        {1'b1, 32'h0210_0400}, {1'b1, 32'hC0C0_C0C0}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // R2: channel n field sits at bits (3-n)*8 +: 8
    function automatic logic [3:0] exp_bit(logic [31:0] w, int pos);
        logic [3:0] e;
        for (int ch = 0; ch < 4; ch++) e[ch] = w[(3 - ch) * 8 + pos];
        return e;
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #1ms;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        // R11 reset state
        chk("R11 pulses", {carrier_load, timing_load, fir_reset, agc_reset,
                           cic_reset, serial_reset, 8'h0}, 32'h0);
        chk("R11 busy/irq/div", {fir_busy, irq, 3'b0, div_reset}, 32'h0);
        chk("R8 in_en after rst", {28'h0, in_en}, 32'h0);
        chk("R8 gated_mode after rst", {31'h0, gated_mode}, 32'h1);

        // vector table: R1 R2 R3 R4 R10
        foreach (VEC[i]) begin
            logic [31:0] w;
            w = VEC[i][31:0];
            ctrl_word  = w;
            div_rst_en = VEC[i][32];
            tick(1);
            sync_in = 1'b1;
            tick(2);
            chk("R1 no pulse before third edge", {28'h0, carrier_load | fir_reset |
                 agc_reset | timing_load | cic_reset | serial_reset}, 32'h0);
            tick(1);
            chk("R3 R2 carrier", {28'h0, carrier_load}, {28'h0, exp_bit(w, 5)});
            chk("R3 R2 fir",     {28'h0, fir_reset},    {28'h0, exp_bit(w, 4)});
            chk("R3 R2 agc",     {28'h0, agc_reset},    {28'h0, exp_bit(w, 3)});
            chk("R3 R2 timing",  {28'h0, timing_load},  {28'h0, exp_bit(w, 2)});
            chk("R3 R2 cic",     {28'h0, cic_reset},    {28'h0, exp_bit(w, 1)});
            chk("R3 R2 serial",  {28'h0, serial_reset}, {28'h0, exp_bit(w, 0)});
            chk("R10 div_reset", {31'h0, div_reset},
                {31'h0, VEC[i][32] & (|exp_bit(w, 0))});
            chk("R7 in_en on sync", {28'h0, in_en}, 32'hF);
            tick(1);
            chk("R4 R1 single pulse", {carrier_load, timing_load, fir_reset,
                 agc_reset, cic_reset, serial_reset, 7'h0, div_reset}, 32'h0);
            sync_in = 1'b0;
            tick(40);
        end

        // R5 busy window length
        ctrl_word = 32'h1000_0000;
        sync_in = 1'b1;
        tick(3);
        sync_in = 1'b0;
        chk("R5 busy with fir_reset", {30'h0, fir_reset[0], fir_busy[0]}, 32'h3);
        begin
            int n = 0;
            while (fir_busy[0] && n < 200) begin n++; tick(1); end
            chk("R5 busy length", n, 32);
        end
        tick(5);

        // R6 restart during window
        sync_in = 1'b1;
        tick(3);
        sync_in = 1'b0;
        begin
            int n = 0;
            while (fir_busy[0] && n < 200) begin
                n++;
                if (n == 11) sync_in = 1'b1;
                if (n == 13) sync_in = 1'b0;
                tick(1);
            end
            chk("R6 restarted busy length", n, 45);
        end
        tick(5);

        // R7 processor reset hold, channel 1 only (bit 22)
        ctrl_word = 32'h0040_0000;
        proc_rst = 1'b1;
        tick(1);
        proc_rst = 1'b0;
        chk("R7 hold on ch1 only", {28'h0, in_en}, 32'hD);
        tick(5);
        chk("R7 hold persists", {28'h0, in_en}, 32'hD);
        sync_in = 1'b1;
        tick(2);
        chk("R7 not released early", {28'h0, in_en}, 32'hD);
        tick(1);
        chk("R7 released on sync", {28'h0, in_en}, 32'hF);
        sync_in = 1'b0;
        tick(3);

        // R9 interrupts on ch0 and ch2
        ctrl_word = 32'h8000_8000;
        out_strobe = 4'hF;
        tick(1);
        out_strobe = 4'h0;
        chk("R9 irq enabled channels", {28'h0, irq}, 32'h5);
        tick(1);
        chk("R9 irq one cycle", {28'h0, irq}, 32'h0);

        // R8 pin reset ignores hold bits, then mode release
        ctrl_word = 32'h0;
        rst = 1'b1;
        tick(1);
        rst = 1'b0;
        chk("R8 pin reset closes all", {28'h0, in_en}, 32'h0);
        chk("R8 gated set", {31'h0, gated_mode}, 32'h1);
        mode_release = 1'b1;
        tick(1);
        mode_release = 1'b0;
        chk("R8 gated released", {31'h0, gated_mode}, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule